// File: doc/BRIEF.md
# Tagged Shift-Down Transmit FIFO

This block sits between a processor write port and the serializer of a bit-oriented link transmitter. Each write stores one payload byte together with two framing tags: end-of-packet and frame-abort. Both tags are copied from control-register bits at the moment the byte is written. Storage is a chain of registers. The serializer always takes the entry at the bottom of the chain. When it does, every entry above moves down one place.

The block presents the bottom entry to the serializer as a data byte plus its two tags. It also reports empty, full and occupancy as registered status. When every slot is occupied, a new write does not get lost or rejected. It replaces the newest stored entry and the occupancy stays the same.

Top module: `txShiftFifo`

## Requirements
- R1: After reset the FIFO is empty: `isEmpty`=1, `isFull`=0, `fillCount`=0.
- R2: A write (`wrEn`=1) into a non-full FIFO stores `{wrAbort, wrEop, wrData}` and raises `fillCount` by one in the following cycle.
- R3: Entries leave in the order they were written. The bottom entry's byte, end-of-packet tag and abort tag appear together on `txData`, `txEop` and `txAbort`.
- R4: A read (`rdReq`=1) while not empty loads the bottom entry into the output register `txData`/`txEop`/`txAbort` on the next cycle, and `txValid` pulses high for that one cycle.
- R5: After a read, every remaining entry moves down one position, and `fillCount` falls by one.
- R6: A read while empty has no effect: the count stays 0, `txValid` stays 0, and `txData`/`txEop`/`txAbort` keep their previous values.
- R7: A write while `fillCount`=DEPTH (default 19) replaces only the most recently written entry. The count stays at DEPTH and older entries are unchanged.
- R8: A write and a read in the same cycle on a non-empty FIFO keep the count constant. The new entry takes its correct place after the shift, including the case where the FIFO is full.
- R9: `isEmpty` is 1 exactly when `fillCount`=0, and `isFull` is 1 exactly when `fillCount`=DEPTH. The count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe from the processor port |
| wrData | input | 8 | Byte to store |
| wrEop | input | 1 | End-of-packet tag from the control register |
| wrAbort | input | 1 | Frame-abort tag from the control register |
| rdReq | input | 1 | Serializer request for the next byte |
| txData | output | 8 | Byte loaded for transmission |
| txEop | output | 1 | End-of-packet tag of the loaded byte |
| txAbort | output | 1 | Abort tag of the loaded byte |
| txValid | output | 1 | One-cycle pulse: a new entry was loaded |
| isEmpty | output | 1 | No entries held |
| isFull | output | 1 | DEPTH entries held |
| fillCount | output | 5 | Number of entries held |

## Verification
The assertions run on every cycle. They check the count arithmetic for each write/read combination and the agreement of the empty and full flags with the count. They also check that the count never goes above DEPTH, and that a read while empty leaves the output stable and raises no valid pulse.

Other behaviour only shows up across a sequence of operations, so the bench scenarios cover it. This includes the order and tag pairing of bytes as they leave the FIFO. It also includes replacing the newest entry when full, and the placement of a byte written during a shift. The bench keeps a queue model to check these.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic                abort;
    logic                eop;
    logic [DATA_W-1:0]   data;
  } fifoEntry_t;

  typedef struct packed {
    logic doShift;
    logic doWrite;
    logic [4:0] wrSlot;
  } fifoCtl_t;
endpackage

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 19,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdReq,
  output fifoCtl_t         ctl,
  output logic             txValid,
  output logic             isEmpty,
  output logic             isFull,
  output logic [CNT_W-1:0] fillCount
);
  logic [CNT_W-1:0] cnt, cntNext;
  logic doRead;

  assign doRead = rdReq && (cnt != '0);

  // Choose the slot that the write lands in.
  always_comb begin
    ctl.doShift = doRead;
    ctl.doWrite = wrEn;
    if (cnt == CNT_W'(DEPTH))
      ctl.wrSlot = doRead ? 5'(DEPTH - 1) : 5'(DEPTH - 1);
    else if (doRead)
      ctl.wrSlot = 5'(cnt - 1'b1);
    else
      ctl.wrSlot = 5'(cnt);
  end

  always_comb begin
    cntNext = cnt;
    if (doRead && !(wrEn && cnt != '0)) cntNext = cnt - 1'b1;
    if (wrEn && !doRead && cnt != CNT_W'(DEPTH)) cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      txValid   <= 1'b0;
      isEmpty   <= 1'b1;
      isFull    <= 1'b0;
    end else begin
      cnt       <= cntNext;
      txValid   <= doRead;
      isEmpty   <= (cntNext == '0);
      isFull    <= (cntNext == CNT_W'(DEPTH));
    end
  end

  assign fillCount = cnt;
endmodule

// File: rtl/txfifo_data.sv
module txfifo_data
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoCtl_t           ctl,
  input  fifoEntry_t         wrEntry,
  output fifoEntry_t         outEntry
);
  fifoEntry_t slots [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      fifoEntry_t above;
      if (i == DEPTH - 1) begin : g_top
        assign above = '0;
      end else begin : g_mid
        assign above = slots[i+1];
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slots[i] <= '0;
        end else if (ctl.doWrite && ctl.wrSlot == 5'(i)) begin
          slots[i] <= wrEntry;
        end else if (ctl.doShift) begin
          slots[i] <= above;
        end
      end
    end
  endgenerate

  // Output register loaded with the bottom entry on a read.
  always_ff @(posedge clk) begin
    if (!rstN)            outEntry <= '0;
    else if (ctl.doShift) outEntry <= slots[0];
  end
endmodule

// File: rtl/txShiftFifo.sv
module txShiftFifo
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 19,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             wrEop,
  input  logic             wrAbort,
  input  logic             rdReq,
  output logic [7:0]       txData,
  output logic             txEop,
  output logic             txAbort,
  output logic             txValid,
  output logic             isEmpty,
  output logic             isFull,
  output logic [CNT_W-1:0] fillCount
);
  fifoCtl_t   ctl;
  fifoEntry_t wrEntry, outEntry;

  assign wrEntry = '{abort: wrAbort, eop: wrEop, data: wrData};

  txfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdReq(rdReq), .ctl(ctl),
    .txValid(txValid), .isEmpty(isEmpty), .isFull(isFull), .fillCount(fillCount)
  );

  txfifo_data #(.DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEntry(wrEntry), .outEntry(outEntry)
  );

  assign txData  = outEntry.data;
  assign txEop   = outEntry.eop;
  assign txAbort = outEntry.abort;
endmodule

// File: rtl/txShiftFifo_chk.sv
module txShiftFifo_chk #(
  parameter int DEPTH = 19,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdReq,
  input logic [7:0]       txData,
  input logic             txEop,
  input logic             txAbort,
  input logic             txValid,
  input logic             isEmpty,
  input logic             isFull,
  input logic [CNT_W-1:0] fillCount
);
  a_r9_empty_flag: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty == (fillCount == '0));
  a_r9_full_flag: assert property (@(posedge clk) disable iff (!rstN)
    isFull == (fillCount == CNT_W'(DEPTH)));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));
  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdReq && !isFull) |=> fillCount == $past(fillCount) + 1'b1);
  a_r5_read_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !wrEn && !isEmpty) |=> fillCount == $past(fillCount) - 1'b1);
  a_r8_both_steady: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && wrEn && !isEmpty) |=> $stable(fillCount));
  a_r7_full_write_steady: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdReq && isFull) |=> isFull);
  a_r6_empty_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && isEmpty) |=> (!txValid && $stable(txData) && $stable(txEop) && $stable(txAbort)));
  a_r4_valid_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !isEmpty) |=> txValid);
endmodule

bind txShiftFifo txShiftFifo_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_txShiftFifo.sv
module test_txShiftFifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 19;

  logic clk = 0, rstN = 0;
  logic wrEn = 0, wrEop = 0, wrAbort = 0, rdReq = 0;
  logic [7:0] wrData = 0;
  logic [7:0] txData;
  logic txEop, txAbort, txValid, isEmpty, isFull;
  logic [4:0] fillCount;

  int checks = 0, errors = 0;
  logic [9:0] model[$];
  logic [9:0] lastOut = 0;

  txShiftFifo #(.DEPTH(DEPTH)) i_txShiftFifo (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] pack(logic ab, logic ep, logic [7:0] d);
    return {ab, ep, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, update model, then check mid-cycle.
  task automatic step(logic w, logic [9:0] e, logic r);
    bit didRead;
    wrEn = w; wrData = e[7:0]; wrEop = e[8]; wrAbort = e[9]; rdReq = r;
    didRead = r && model.size() > 0;
    if (didRead) lastOut = model.pop_front();
    if (w) begin
      if (model.size() == DEPTH) model[DEPTH-1] = e;
      else model.push_back(e);
    end
    @(posedge clk); #1;
    wrEn = 0; rdReq = 0;
    check("R9 count", fillCount, model.size());
    check("R9 empty", isEmpty, model.size() == 0);
    check("R9 full", isFull, model.size() == DEPTH);
    check(didRead ? "R4 valid" : "R6 valid", txValid, didRead);
    check(didRead ? "R3 entry" : "R6 hold", {txAbort, txEop, txData}, lastOut);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    rstN = 1; #1;
    check("R1 empty", isEmpty, 1);
    check("R1 full", isFull, 0);
    check("R1 count", fillCount, 0);
    // R6: read when empty
    step(0, 0, 1);
    // R2 / R3 directed
    step(1, pack(0, 1, 8'hA5), 0);
    step(1, pack(1, 0, 8'h3C), 0);
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);  // R6 again
    // Fill to full then overwrite newest (R7)
    for (int i = 0; i < DEPTH; i++) step(1, pack(i[0], i[1], 8'(i)), 0);
    step(1, pack(1, 1, 8'hEE), 0);
    step(1, pack(0, 1, 8'hDD), 0);
    // R8 full with read+write
    step(1, pack(1, 0, 8'h77), 1);
    // Drain and check order (R5)
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
    step(0, 0, 1);
    // R8 simultaneous at partial fill
    step(1, pack(0, 0, 8'h11), 0);
    step(1, pack(0, 1, 8'h22), 1);
    step(0, 0, 1);
    // Random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv = $urandom;
      step(rv[0] | rv[1], rv[13:4], rv[2] & rv[3] | rv[20]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule